// File: doc/BRIEF.md
# Priority Round-Robin Memory Arbiter

This block hands one shared memory port to one of several client sockets at a time. Each socket drives a request line, a done line and a small priority value. When no socket owns the port, the arbiter looks at the current requests and keeps only those that share the largest priority value. Among that group it grants the socket whose previous grant is the oldest. Clients that are still waiting therefore get their turn in a rotating order.

A grant does not preempt. The owner keeps the port for a whole list of reads and writes, however long that list is. It gives the port back by pulling its own done line for one cycle. Done pulses from sockets that do not own the port have no effect. The grant is a one-hot vector with a separate valid bit. The memory controller and the data path sit outside this block. The reset input is assumed to be released synchronously by the surrounding reset logic.

Top module: `prio_rr_arbiter`

## Requirements
- R1: After reset, and at every cycle after that, `grant_o` has at most one bit set. `grant_vld_o` is high exactly when one bit of `grant_o` is set. While reset is active, both are zero.
- R2: Suppose no socket owns the port and at least one `req_i` bit is high at a rising edge. From that edge on, `grant_vld_o` is high and `grant_o` shows a socket that was requesting at that edge.
- R3: While a socket owns the port, `grant_o` stays the same until the owner's own `done_i` bit is high at an edge. The owner keeps the grant even if its request drops. Requests from other sockets and done bits from other sockets do not change the grant.
- R4: When the owner's `done_i` bit is high at an edge, `grant_vld_o` and `grant_o` go to zero after that edge. The next grant is decided at the following edge.
- R5: Socket i takes its priority from `prio_i[2*i+1:2*i]`, and a larger value means higher priority. The new owner always has the largest priority value among the sockets requesting at the granting edge.
- R6: When several requesters share that largest priority, the grant goes to the one granted least recently.
- R7: After reset, no socket has a grant history yet. Ties are then broken by index, and the lowest index counts as the oldest.
- R8: Each socket holds a distinct age rank. The socket just granted becomes the newest. Every socket that was newer than it moves one step older. All other sockets keep their rank.
- R9: If no socket owns the port and no request is high at an edge, the arbiter stays idle with `grant_vld_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | One request bit per socket |
| done_i | input | 4 | End-of-transaction-list pulse per socket; only the owner's bit is used |
| prio_i | input | 8 | Two-bit priority per socket, socket i in bits 2i+1:2i |
| grant_o | output | 4 | One-hot grant to the current owner |
| grant_vld_o | output | 1 | High while some socket owns the port |

## Verification
Every result here comes one register stage after its cause:
- A new grant appears right after the edge that sampled the requests.
- A release appears right after the edge that sampled the owner's done.
- An age update counts from the granting edge, so it only shows up in the next grant decision.

The bench changes its inputs on the falling edge. It samples the outputs shortly after the following rising edge. Each row of the vector table therefore describes exactly one edge of cause and its effect. The age order cannot be seen on its own. It is checked through the sequence of grants that follows.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_BUSY = 1'b1
  } own_state_e;
endpackage

// File: rtl/arb_age_track.sv
// Per-socket age rank: 0 is the oldest grant, NUM_SOCK-1 the newest.
module arb_age_track #(
  parameter int NUM_SOCK = 4,
  parameter int AW       = $clog2(NUM_SOCK)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  logic [AW-1:0]         upd_idx,
  output logic [NUM_SOCK*AW-1:0] age_o
);
  logic [AW-1:0] age_q [NUM_SOCK];
  logic [AW-1:0] age_d [NUM_SOCK];

  always_comb begin
    for (int i = 0; i < NUM_SOCK; i++) begin
      age_d[i] = age_q[i];
      if (upd_en) begin
        if (upd_idx == AW'(i))
          age_d[i] = AW'(NUM_SOCK - 1);
        else if (age_q[i] > age_q[upd_idx])
          age_d[i] = age_q[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SOCK; i++) age_q[i] <= AW'(i);
    end else if (upd_en) begin
      for (int i = 0; i < NUM_SOCK; i++) age_q[i] <= age_d[i];
    end
  end

  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_out
    assign age_o[g*AW +: AW] = age_q[g];
  end

  // R8: the ranks remain a permutation (all distinct)
  for (genvar a = 0; a < NUM_SOCK; a++) begin : g_ua
    for (genvar b = a + 1; b < NUM_SOCK; b++) begin : g_ub
      assert_age_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
        age_q[a] != age_q[b]);
    end
  end
endmodule

// File: rtl/arb_pick.sv
// Combinational choice: keep the top priority class, then the oldest rank.
module arb_pick #(
  parameter int NUM_SOCK = 4,
  parameter int PW       = 2,
  parameter int AW       = $clog2(NUM_SOCK)
) (
  input  logic [NUM_SOCK-1:0]    req,
  input  logic [NUM_SOCK*PW-1:0] prio,
  input  logic [NUM_SOCK*AW-1:0] age,
  output logic                   any_o,
  output logic [AW-1:0]          win_o
);
  logic [PW-1:0] top_p;
  logic [AW-1:0] best_age;
  logic          found;

  always_comb begin
    top_p = '0;
    for (int i = 0; i < NUM_SOCK; i++) begin
      if (req[i] && (prio[i*PW +: PW] > top_p)) top_p = prio[i*PW +: PW];
    end
    found    = 1'b0;
    best_age = '1;
    win_o    = '0;
    for (int i = 0; i < NUM_SOCK; i++) begin
      if (req[i] && (prio[i*PW +: PW] == top_p) &&
          (!found || (age[i*AW +: AW] < best_age))) begin
        found    = 1'b1;
        best_age = age[i*AW +: AW];
        win_o    = AW'(i);
      end
    end
    any_o = |req;
  end
endmodule

// File: rtl/prio_rr_arbiter.sv
module prio_rr_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_SOCK = 4,
  parameter int PW       = 2,
  localparam int AW      = $clog2(NUM_SOCK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SOCK-1:0]    req_i,
  input  logic [NUM_SOCK-1:0]    done_i,
  input  logic [NUM_SOCK*PW-1:0] prio_i,
  output logic [NUM_SOCK-1:0]    grant_o,
  output logic                   grant_vld_o
);
  own_state_e    st_q, st_d;
  logic [AW-1:0] owner_q, owner_d;
  logic [NUM_SOCK*AW-1:0] age_w;
  logic          any_w;
  logic [AW-1:0] win_w;
  logic          take_w;
  logic          own_done_w;

  arb_age_track #(.NUM_SOCK(NUM_SOCK), .AW(AW)) age_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (take_w),
    .upd_idx (win_w),
    .age_o   (age_w)
  );

  arb_pick #(.NUM_SOCK(NUM_SOCK), .PW(PW), .AW(AW)) pick_i (
    .req   (req_i),
    .prio  (prio_i),
    .age   (age_w),
    .any_o (any_w),
    .win_o (win_w)
  );

  assign own_done_w = done_i[owner_q];
  assign take_w     = (st_q == OWN_IDLE) && any_w;

  always_comb begin
    st_d    = st_q;
    owner_d = owner_q;
    case (st_q)
      OWN_IDLE: if (any_w) begin
        st_d    = OWN_BUSY;
        owner_d = win_w;
      end
      OWN_BUSY: if (own_done_w) st_d = OWN_IDLE;
      default:  st_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= OWN_IDLE;
      owner_q <= '0;
    end else begin
      st_q    <= st_d;
      if (take_w) owner_q <= owner_d;
    end
  end

  assign grant_vld_o = (st_q == OWN_BUSY);
  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_gnt
    assign grant_o[g] = grant_vld_o && (owner_q == AW'(g));
  end

  // R1: one owner at most, valid matches the vector
  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (grant_vld_o == (grant_o != '0)));
  // R2: idle with a request -> granted after the edge
  assert_grant_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld_o && (req_i != '0)) |=> grant_vld_o);
  // R3: no owner done -> grant unchanged
  assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && ((done_i & grant_o) == '0)) |=> (grant_vld_o && $stable(grant_o)));
  // R4: owner done -> released
  assert_grant_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && ((done_i & grant_o) != '0)) |=> !grant_vld_o);
  // R2: a fresh grant always goes to a socket that was requesting
  assert_grant_was_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld_o) |-> (($past(req_i) & grant_o) != '0));
  // R9: idle and no requests -> still idle
  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld_o && (req_i == '0)) |=> !grant_vld_o);
endmodule

// File: tb/prio_rr_arbiter_tb.sv
`timescale 1ns/1ps
module prio_rr_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req_i, done_i, grant_o;
  logic [7:0] prio_i;
  logic       grant_vld_o;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  prio_rr_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
    .prio_i(prio_i), .grant_o(grant_o), .grant_vld_o(grant_vld_o)
  );

  // {tag, req, done, prio, exp_grant, exp_vld}
  localparam int NV = 19;
  localparam logic [24:0] VEC [NV] = '{
    {4'd9, 4'b0000, 4'b0000, 8'h00, 4'b0000, 1'b0}, // R9 idle
    {4'd7, 4'b1111, 4'b0000, 8'h00, 4'b0001, 1'b1}, // R7 index 0 oldest
    {4'd3, 4'b1111, 4'b1110, 8'h00, 4'b0001, 1'b1}, // R3 foreign done
    {4'd3, 4'b0000, 4'b0000, 8'h00, 4'b0001, 1'b1}, // R3 req dropped
    {4'd4, 4'b1111, 4'b0001, 8'h00, 4'b0000, 1'b0}, // R4 release
    {4'd6, 4'b1111, 4'b0000, 8'h00, 4'b0010, 1'b1}, // R6 oldest s1
    {4'd4, 4'b1111, 4'b0010, 8'h00, 4'b0000, 1'b0}, // R4
    {4'd8, 4'b1001, 4'b0000, 8'h00, 4'b1000, 1'b1}, // R8 s3 older than s0
    {4'd4, 4'b0000, 4'b1000, 8'h00, 4'b0000, 1'b0}, // R4
    {4'd9, 4'b0000, 4'b0000, 8'h00, 4'b0000, 1'b0}, // R9
    {4'd5, 4'b1111, 4'b0000, 8'h08, 4'b0010, 1'b1}, // R5 s1 top prio
    {4'd4, 4'b0000, 4'b0010, 8'h08, 4'b0000, 1'b0}, // R4
    {4'd5, 4'b1111, 4'b0000, 8'hC3, 4'b0001, 1'b1}, // R5 s0,s3 class
    {4'd4, 4'b0000, 4'b0001, 8'hC3, 4'b0000, 1'b0}, // R4
    {4'd8, 4'b1001, 4'b0000, 8'hC3, 4'b1000, 1'b1}, // R8 s0 now newest
    {4'd4, 4'b0000, 4'b1000, 8'hC3, 4'b0000, 1'b0}, // R4
    {4'd6, 4'b0111, 4'b0000, 8'h00, 4'b0100, 1'b1}, // R6 s2 oldest
    {4'd4, 4'b0111, 4'b0100, 8'h00, 4'b0000, 1'b0}, // R4
    {4'd8, 4'b0111, 4'b0000, 8'h00, 4'b0010, 1'b1}  // R8 s1 aged past s0
  };

  task automatic check(input int tag, input logic [3:0] eg, input logic ev);
    total++;
    if (grant_o !== eg || grant_vld_o !== ev) begin
      bad++;
      $display("FAIL R%0d: grant=%b vld=%b expected grant=%b vld=%b",
               tag, grant_o, grant_vld_o, eg, ev);
    end
  endtask

  task automatic step(input logic [3:0] rq, input logic [3:0] dn, input logic [7:0] pr);
    @(negedge clk);
    req_i = rq; done_i = dn; prio_i = pr;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = '0; done_i = '0; prio_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check(1, 4'b0000, 1'b0); // R1 reset state
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][20:17], VEC[k][16:13], VEC[k][12:5]);
      check(int'(VEC[k][24:21]), VEC[k][4:1], VEC[k][0]);
    end
    // R7: reset in the middle of a grant restores index order
    @(negedge clk) rst_n = 1'b0;
    #1 check(1, 4'b0000, 1'b0); // R1 async clear
    @(negedge clk) rst_n = 1'b1;
    step(4'b1111, 4'b0000, 8'h00);
    check(7, 4'b0001, 1'b1); // R7
    step(4'b1110, 4'b0000, 8'h00);
    check(3, 4'b0001, 1'b1); // R3 others waiting
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule